// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one column access request into the ordered list of column indices that a double-data-rate burst touches. A request carries a starting column, a burst-length code and an ordering bit. Once accepted, the block walks an aligned block of 4 or 8 columns that contains the start column. It emits two indices per clock: an even beat and an odd beat, matching two data transfers per controller clock. A valid strobe and a final-pair flag go with the indices.

The walk either counts upward and wraps inside the aligned block (sequential), or flips low address bits against a beat counter (interleaved). Column bits above the aligned block are copied to every beat. A truncation input lets an 8-beat burst stop after its fourth beat, as happens when the next column command follows at the minimum command spacing. A new request that arrives in the final pair cycle starts its burst on the next clock with no gap.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `beat_vld_o` and `beat_last_o` are 0.
- R2: A request is accepted only when `blen_code_i` is 3'b010 (4 beats, 2 cycles of output) or 3'b011 (8 beats, 4 cycles of output). A request with any other code is ignored and leaves the block idle. The first pair appears in the cycle after the accepting edge.
- R3: With `order_i` = 0 (sequential), beat k uses offset (s + k) mod L inside the aligned block. Here s is the start offset within the block and L is the burst length.
- R4: With `order_i` = 1 (interleaved), beat k uses offset s XOR k inside the aligned block.
- R5: For a 4-beat burst, only start column bits [1:0] take part in the ordering, and bit 2 of the start column is held on every beat.
- R6: Column bits [COL_W-1:3] of the start column appear unchanged on every beat of both lanes.
- R7: Each valid cycle p carries beat 2p on `col_even_o` and beat 2p+1 on `col_odd_o`.
- R8: `beat_last_o` is 1 exactly in the final pair cycle of a burst. `beat_vld_o` stays 1 from the first pair to the final pair, and both outputs are 0 when idle.
- R9: `chop_i` high together with an accepted 8-beat request, or in the first pair cycle of an 8-beat burst, ends the burst after beat 3. `chop_i` in any later cycle, or during a 4-beat burst, has no effect.
- R10: A legal request in the final pair cycle is accepted and its first pair appears on the next clock. A request in any other cycle of an active burst is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Burst request |
| start_col_i | input | COL_W | Starting column of the request |
| blen_code_i | input | 3 | Burst-length code: 010 = 4 beats, 011 = 8 beats |
| order_i | input | 1 | 0 = sequential, 1 = interleaved |
| chop_i | input | 1 | Truncate an 8-beat burst to 4 beats |
| beat_vld_o | output | 1 | A pair of beat indices is present |
| col_even_o | output | COL_W | Column index of beat 2p |
| col_odd_o | output | COL_W | Column index of beat 2p+1 |
| beat_last_o | output | 1 | This cycle carries the final pair |

## Verification
The bench checks that wrap-around stays inside the aligned block. A design that carried into bit 2 or into the upper column bits would produce a column outside the block, for example 8 after 7 in a sequential 8-beat burst from 5. For 4-beat bursts whose start has bit 2 set, a sequencer that let bit 2 take part in the walk would toggle it. Truncation is tried at the request edge, in the first pair cycle and too late; a sequencer with the wrong window would end the burst one pair early or late. Back-to-back and mid-burst requests are driven as well: a design that dropped the chained request would show an idle cycle, and one that accepted an early request would corrupt the running order.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int OFF_W         = 3;
    localparam int BEATS_PER_CLK = 2;
    localparam int PAIR_W        = 2;

    typedef enum logic [2:0] {
        BLC_FOUR  = 3'b010,
        BLC_EIGHT = 3'b011
    } blen_code_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    typedef struct packed {
        logic             bl8;
        order_e           order;
        logic [OFF_W-1:0] off;
    } burst_cfg_t;

    function automatic logic [OFF_W-1:0] beat_offset(input burst_cfg_t c,
                                                     input logic [OFF_W-1:0] k);
        logic [OFF_W-1:0] sum;
        logic [OFF_W-1:0] flip;
        sum  = c.off + k;
        flip = c.off ^ k;
        if (c.bl8)
            return (c.order == ORD_ILV) ? flip : sum;
        else
            return {c.off[2], (c.order == ORD_ILV) ? flip[1:0] : sum[1:0]};
    endfunction

endpackage

// File: rtl/bcs_req_decode.sv
module bcs_req_decode
    import bcs_pkg::*;
#(
    parameter int COL_W = 10,
    localparam int UP_W = COL_W - OFF_W
) (
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       blen_code_i,
    input  logic             order_i,
    output logic             req_ok_o,
    output burst_cfg_t       cfg_o,
    output logic [UP_W-1:0]  upper_o
);
    logic code_four;
    logic code_eight;

    always_comb begin
        code_four  = (blen_code_i == BLC_FOUR);
        code_eight = (blen_code_i == BLC_EIGHT);
        req_ok_o   = start_i && (code_four || code_eight);
        cfg_o.bl8  = code_eight;
        cfg_o.order = order_e'(order_i);
        cfg_o.off  = start_col_i[OFF_W-1:0];
        upper_o    = start_col_i[COL_W-1:OFF_W];
    end
endmodule

// File: rtl/bcs_burst_ctrl.sv
module bcs_burst_ctrl
    import bcs_pkg::*;
#(
    parameter int UP_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_ok_i,
    input  burst_cfg_t        cfg_i,
    input  logic [UP_W-1:0]   upper_i,
    input  logic              chop_i,
    output logic              active_o,
    output burst_cfg_t        cfg_o,
    output logic [UP_W-1:0]   upper_o,
    output logic [PAIR_W-1:0] pair_o,
    output logic              last_o
);
    logic              active_q;
    burst_cfg_t        cfg_q;
    logic [UP_W-1:0]   upper_q;
    logic [PAIR_W-1:0] pair_q;
    logic              cut_q;
    logic [PAIR_W-1:0] final_pair;
    logic              last;
    logic              accept;

    always_comb begin
        final_pair = (cfg_q.bl8 && !cut_q) ? PAIR_W'(3) : PAIR_W'(1);
        last       = active_q && (pair_q == final_pair);
        accept     = req_ok_i && (!active_q || last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cfg_q    <= '0;
            upper_q  <= '0;
            pair_q   <= '0;
            cut_q    <= 1'b0;
        end else if (accept) begin
            active_q <= 1'b1;
            cfg_q    <= cfg_i;
            upper_q  <= upper_i;
            pair_q   <= '0;
            cut_q    <= chop_i && cfg_i.bl8;
        end else if (active_q) begin
            if (last) begin
                active_q <= 1'b0;
                cut_q    <= 1'b0;
            end else begin
                pair_q <= pair_q + PAIR_W'(1);
                if (chop_i && cfg_q.bl8 && (pair_q == '0))
                    cut_q <= 1'b1;
            end
        end
    end

    assign active_o = active_q;
    assign cfg_o    = cfg_q;
    assign upper_o  = upper_q;
    assign pair_o   = pair_q;
    assign last_o   = last;
endmodule

// File: rtl/bcs_beat_gen.sv
module bcs_beat_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 10,
    localparam int UP_W = COL_W - OFF_W
) (
    input  logic                                active_i,
    input  burst_cfg_t                          cfg_i,
    input  logic [UP_W-1:0]                     upper_i,
    input  logic [PAIR_W-1:0]                   pair_i,
    output logic [BEATS_PER_CLK-1:0][COL_W-1:0] col_o
);
    for (genvar ln = 0; ln < BEATS_PER_CLK; ln++) begin : g_lane
        logic [OFF_W-1:0] beat_k;
        logic [OFF_W-1:0] off;
        always_comb begin
            beat_k = {pair_i, 1'(ln)};
            off    = beat_offset(cfg_i, beat_k);
            col_o[ln] = active_i ? {upper_i, off} : '0;
        end
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       blen_code_i,
    input  logic             order_i,
    input  logic             chop_i,
    output logic             beat_vld_o,
    output logic [COL_W-1:0] col_even_o,
    output logic [COL_W-1:0] col_odd_o,
    output logic             beat_last_o
);
    localparam int UP_W = COL_W - OFF_W;

    logic                                req_ok;
    burst_cfg_t                          req_cfg;
    logic [UP_W-1:0]                     req_upper;
    logic                                act;
    burst_cfg_t                          cur_cfg;
    logic [UP_W-1:0]                     cur_upper;
    logic [PAIR_W-1:0]                   cur_pair;
    logic                                cur_last;
    logic [BEATS_PER_CLK-1:0][COL_W-1:0] lanes;

    bcs_req_decode #(.COL_W(COL_W)) u_dec (
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .blen_code_i (blen_code_i),
        .order_i     (order_i),
        .req_ok_o    (req_ok),
        .cfg_o       (req_cfg),
        .upper_o     (req_upper)
    );

    bcs_burst_ctrl #(.UP_W(UP_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req_ok_i (req_ok),
        .cfg_i    (req_cfg),
        .upper_i  (req_upper),
        .chop_i   (chop_i),
        .active_o (act),
        .cfg_o    (cur_cfg),
        .upper_o  (cur_upper),
        .pair_o   (cur_pair),
        .last_o   (cur_last)
    );

    bcs_beat_gen #(.COL_W(COL_W)) u_gen (
        .active_i (act),
        .cfg_i    (cur_cfg),
        .upper_i  (cur_upper),
        .pair_i   (cur_pair),
        .col_o    (lanes)
    );

    assign beat_vld_o  = act;
    assign beat_last_o = cur_last;
    assign col_even_o  = lanes[0];
    assign col_odd_o   = lanes[1];
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       blen_code_i,
    input logic             beat_vld_o,
    input logic [COL_W-1:0] col_even_o,
    input logic [COL_W-1:0] col_odd_o,
    input logic             beat_last_o
);
    logic legal;
    assign legal = (blen_code_i == 3'b010) || (blen_code_i == 3'b011);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!beat_vld_o && !beat_last_o));

    assert_start_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && legal && !beat_vld_o) |=> beat_vld_o);

    assert_illegal_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !legal && !beat_vld_o) |=> !beat_vld_o);

    assert_upper_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (beat_vld_o && !beat_last_o) |=>
            (col_even_o[COL_W-1:3] == $past(col_even_o[COL_W-1:3])));

    assert_lane_pair_R7: assert property (@(posedge clk) disable iff (rst)
        beat_vld_o |-> ((col_even_o[0] != col_odd_o[0]) &&
                        (col_even_o[COL_W-1:3] == col_odd_o[COL_W-1:3])));

    assert_idle_no_last_R8: assert property (@(posedge clk) disable iff (rst)
        !beat_vld_o |-> !beat_last_o);

    assert_burst_runs_R8: assert property (@(posedge clk) disable iff (rst)
        (beat_vld_o && !beat_last_o) |=> beat_vld_o);

    assert_chain_R10: assert property (@(posedge clk) disable iff (rst)
        (start_i && legal && beat_last_o) |=>
            (beat_vld_o && col_even_o[COL_W-1:3] == $past(start_col_i[COL_W-1:3])));
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_bcs_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .blen_code_i (blen_code_i),
    .beat_vld_o  (beat_vld_o),
    .col_even_o  (col_even_o),
    .col_odd_o   (col_odd_o),
    .beat_last_o (beat_last_o)
);

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst;
    logic             start_i;
    logic [COL_W-1:0] start_col_i;
    logic [2:0]       blen_code_i;
    logic             order_i;
    logic             chop_i;
    logic             beat_vld_o;
    logic [COL_W-1:0] col_even_o;
    logic [COL_W-1:0] col_odd_o;
    logic             beat_last_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) dut (.*);

    // vector: {code[2:0], ilv, chop_at_start, chop_first_pair, chop_late, col[9:0]}
    localparam logic [16:0] VEC [12] = '{
        {3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 10'h001},
        {3'b010, 1'b1, 1'b0, 1'b0, 1'b0, 10'h001},
        {3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 10'h005},
        {3'b011, 1'b1, 1'b0, 1'b0, 1'b0, 10'h005},
        {3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 10'h3A6},
        {3'b010, 1'b1, 1'b0, 1'b0, 1'b0, 10'h2B7},
        {3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 10'h15B},
        {3'b011, 1'b1, 1'b0, 1'b0, 1'b0, 10'h0FE},
        {3'b011, 1'b0, 1'b1, 1'b0, 1'b0, 10'h105},
        {3'b011, 1'b1, 1'b0, 1'b1, 1'b0, 10'h203},
        {3'b011, 1'b0, 1'b0, 1'b0, 1'b1, 10'h07A},
        {3'b010, 1'b1, 1'b1, 1'b0, 1'b0, 10'h3FF}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_col(input int col, input int k, input bit bl8, input bit ilv);
        int len, inblk, base;
        len   = bl8 ? 8 : 4;
        inblk = col % len;
        base  = col - inblk;
        if (ilv) return base + (inblk ^ k);
        return base + ((inblk + k) % len);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run_burst(input logic [2:0] code, input bit ilv, input int col,
                             input bit cs, input bit cp0, input bit clate);
        bit bl8;
        int npairs;
        string otag;
        string ltag;
        bl8    = (code == 3'b011);
        npairs = (bl8 && !cs && !cp0) ? 4 : 2;
        otag   = ilv ? "R4" : "R3";
        ltag   = (cs || cp0 || clate) ? "R9" : "R8";
        start_i = 1'b1; start_col_i = COL_W'(col); blen_code_i = code;
        order_i = ilv; chop_i = cs;
        tick();
        start_i = 1'b0; chop_i = 1'b0;
        for (int p = 0; p < npairs; p++) begin
            chk("R2 valid during burst", int'(beat_vld_o), 1);
            chk(otag, int'(col_even_o), exp_col(col, 2*p, bl8, ilv));
            chk("R7 odd lane", int'(col_odd_o), exp_col(col, 2*p+1, bl8, ilv));
            chk(ltag, int'(beat_last_o), (p == npairs-1) ? 1 : 0);
            chk("R6 upper bits", int'(col_even_o[COL_W-1:3]), col >> 3);
            if (!bl8) chk("R5 bit2 held", int'(col_even_o[2]), (col >> 2) & 1);
            if (p == 0 && cp0) chop_i = 1'b1;
            if (p == 1 && clate) chop_i = 1'b1;
            tick();
            chop_i = 1'b0;
        end
        chk(ltag, int'(beat_vld_o), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; start_col_i = '0; blen_code_i = 3'b010;
        order_i = 1'b0; chop_i = 1'b0;
        tick(); tick();
        chk("R1 reset valid", int'(beat_vld_o), 0);
        chk("R1 reset last", int'(beat_last_o), 0);
        rst = 1'b0;
        tick();

        for (int i = 0; i < 12; i++)
            run_burst(VEC[i][16:14], VEC[i][13], int'(VEC[i][9:0]),
                      VEC[i][12], VEC[i][11], VEC[i][10]);

        // R2: illegal codes ignored
        start_i = 1'b1; blen_code_i = 3'b000; start_col_i = 10'h011;
        tick();
        chk("R2 code 000 ignored", int'(beat_vld_o), 0);
        blen_code_i = 3'b111;
        tick();
        start_i = 1'b0;
        chk("R2 code 111 ignored", int'(beat_vld_o), 0);
        tick();

        // R10: mid-burst request ignored
        start_i = 1'b1; blen_code_i = 3'b011; order_i = 1'b0; start_col_i = 10'h040;
        tick();
        start_i = 1'b1; blen_code_i = 3'b010; order_i = 1'b1; start_col_i = 10'h3C3;
        tick();
        start_i = 1'b0;
        chk("R10 mid request ignored even", int'(col_even_o), 10'h042);
        chk("R10 mid request ignored odd", int'(col_odd_o), 10'h043);
        tick(); tick();
        chk("R10 original burst ends", int'(beat_last_o), 1);
        tick();
        chk("R10 no burst from mid request", int'(beat_vld_o), 0);

        // R10: chained request in final pair cycle
        start_i = 1'b1; blen_code_i = 3'b010; order_i = 1'b0; start_col_i = 10'h102;
        tick();
        start_i = 1'b0;
        tick();
        chk("R10 first burst final pair", int'(beat_last_o), 1);
        start_i = 1'b1; blen_code_i = 3'b011; order_i = 1'b1; start_col_i = 10'h2F6;
        tick();
        start_i = 1'b0;
        chk("R10 chained valid", int'(beat_vld_o), 1);
        chk("R10 chained even", int'(col_even_o), 10'h2F6);
        chk("R10 chained odd", int'(col_odd_o), 10'h2F7);
        chk("R10 chained not last", int'(beat_last_o), 0);

        // R1: reset in mid-burst
        rst = 1'b1;
        tick();
        chk("R1 reset mid burst valid", int'(beat_vld_o), 0);
        chk("R1 reset mid burst last", int'(beat_last_o), 0);
        rst = 1'b0;
        tick();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule